// File: doc/BRIEF.md
# Comma Word Aligner

This block sits behind a deserializer that delivers recovered 8b/10b line bits as 10-bit words whose boundary is arbitrary. It keeps a window spanning the previous and current words. In every cycle it scans all ten bit offsets of that window in parallel for the seven-bit comma prefix of K28.5, in either disparity. A hit moves the stored word boundary to the offset where the comma was found, with no further qualification.

From then on, each output character is cut from the window at the stored offset. The comma character is flagged on a one-cycle sync strobe. Data and strobe leave the same output register, so downstream logic captures both on one rising edge.

Characters output before a realigned comma are not guaranteed. The fixed three-register pipeline bounds that window to the characters still in flight. A comma that arrives at the current offset passes through without disturbing anything.

Top module: `cwa_aligner`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears data_o and sync_o to zero and sets the stored offset to 0, so a stream whose characters start at bit 0 of each word is output unchanged with no comma seen.
- R2: Input bit 0 is the earliest bit on the line. The window is {current word, previous word}, and the character at offset k is window bits k+9 down to k. The character whose lower word is sampled at clock edge E appears on data_o after edge E+3.
- R3: A comma is detected at offset k (0 to 9) when window bits k+6 down to k equal 7'b1111100 or 7'b0000011. These are the prefixes 0011111 and 1100000 in line order, and both disparities are detected at every offset, including 9.
- R4: On detection at offset k, the stored offset becomes k. The comma character and every character after it are output cut at offset k.
- R5: When several offsets match in one window, the lowest offset is taken.
- R6: sync_o is 1 in exactly the cycle in which data_o holds a comma character, and 0 while data_o holds any other checked character.
- R7: Each comma gives a one-cycle strobe. Two back-to-back commas give strobes in two consecutive cycles, and the strobe drops on the next character.
- R8: A comma at the current offset leaves the offset unchanged. Characters before and after it are output intact.
- R9: With no comma detected, the stored offset is held, and a long run of data stays aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 10 | Unaligned received word, bit 0 earliest |
| data_o | output | 10 | Aligned character |
| sync_o | output | 1 | High while data_o holds a comma character |

## Verification
Realignment and the strobe can land in the same cycle. A comma at a new offset must change the cut and raise sync_o on that very character. The bench provokes this by shifting the character phase between scenarios (offsets 3, 7, 9, 0, 5, 1) and by placing a word where two offsets match at once. Each character from the comma onward is judged against the stream the bench built, together with the expected strobe value. Back-to-back commas in opposite disparities check that two strobes, each with its own offset update, also coincide correctly in consecutive cycles.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  localparam int DEF_CHAR_W = 10;
  localparam int DEF_PFX_W  = 7;
  // comma prefix, bit 0 first on the line; the other disparity is its inverse
  localparam logic [DEF_PFX_W-1:0] DEF_PFX = 7'b1111100;
endpackage

// File: rtl/cwa_window.sv
module cwa_window #(
  parameter int CHAR_W = 10,
  localparam int WIN_W = 2*CHAR_W-1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] data_i,
  output logic [WIN_W-1:0]  win_o
);
  logic [CHAR_W-1:0] prev_q;

  // top bit of the newest word is never needed in the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      win_o  <= '0;
    end else begin
      prev_q <= data_i;
      win_o  <= {data_i[CHAR_W-2:0], prev_q};
    end
  end
endmodule

// File: rtl/cwa_comma_scan.sv
module cwa_comma_scan #(
  parameter int CHAR_W = 10,
  parameter int PFX_W  = 7,
  parameter logic [PFX_W-1:0] PFX_P = 7'b1111100,
  localparam int SCAN_W = CHAR_W+PFX_W-1,
  localparam int OFF_W  = $clog2(CHAR_W)
) (
  input  logic [SCAN_W-1:0] win_i,
  output logic [CHAR_W-1:0] hit_vec_o,
  output logic              hit_o,
  output logic [OFF_W-1:0]  off_o
);
  for (genvar k = 0; k < CHAR_W; k++) begin : g_off
    assign hit_vec_o[k] = (win_i[k +: PFX_W] == PFX_P) ||
                          (win_i[k +: PFX_W] == ~PFX_P);
  end

  assign hit_o = |hit_vec_o;

  // lowest matching offset wins
  always_comb begin
    off_o = '0;
    for (int k = CHAR_W-1; k >= 0; k--) begin
      if (hit_vec_o[k]) off_o = OFF_W'(k);
    end
  end
endmodule

// File: rtl/cwa_barrel.sv
module cwa_barrel #(
  parameter int CHAR_W = 10,
  localparam int WIN_W = 2*CHAR_W-1,
  localparam int OFF_W = $clog2(CHAR_W)
) (
  input  logic [WIN_W-1:0]  win_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [CHAR_W-1:0] char_o
);
  logic [CHAR_W-1:0] cand [CHAR_W];

  for (genvar k = 0; k < CHAR_W; k++) begin : g_cand
    assign cand[k] = win_i[k +: CHAR_W];
  end

  always_comb begin
    char_o = cand[0];
    for (int k = 1; k < CHAR_W; k++) begin
      if (off_i == OFF_W'(k)) char_o = cand[k];
    end
  end
endmodule

// File: rtl/cwa_aligner.sv
module cwa_aligner
  import cwa_pkg::*;
#(
  parameter int CHAR_W = DEF_CHAR_W,
  parameter int PFX_W  = DEF_PFX_W,
  parameter logic [PFX_W-1:0] PFX_P = DEF_PFX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] data_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              sync_o
);
  localparam int WIN_W  = 2*CHAR_W-1;
  localparam int SCAN_W = CHAR_W+PFX_W-1;
  localparam int OFF_W  = $clog2(CHAR_W);

  logic [WIN_W-1:0]  win_a;
  logic [WIN_W-1:0]  win_b;
  logic [CHAR_W-1:0] hit_vec;
  logic              hit;
  logic [OFF_W-1:0]  hit_off;
  logic [OFF_W-1:0]  off_q;
  logic              sync_b;
  logic [CHAR_W-1:0] char_b;

  cwa_window #(.CHAR_W(CHAR_W)) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .win_o  (win_a)
  );

  cwa_comma_scan #(
    .CHAR_W (CHAR_W),
    .PFX_W  (PFX_W),
    .PFX_P  (PFX_P)
  ) u_scan (
    .win_i     (win_a[SCAN_W-1:0]),
    .hit_vec_o (hit_vec),
    .hit_o     (hit),
    .off_o     (hit_off)
  );

  // offset moves together with the window that held the comma
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_b  <= '0;
      sync_b <= 1'b0;
      off_q  <= '0;
    end else begin
      win_b  <= win_a;
      sync_b <= hit;
      if (hit) off_q <= hit_off;
    end
  end

  cwa_barrel #(.CHAR_W(CHAR_W)) u_barrel (
    .win_i  (win_b),
    .off_i  (off_q),
    .char_o (char_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      sync_o <= 1'b0;
    end else begin
      data_o <= char_b;
      sync_o <= sync_b;
    end
  end
endmodule

// File: rtl/cwa_aligner_chk.sv
module cwa_aligner_chk #(
  parameter int CHAR_W = 10,
  parameter int PFX_W  = 7,
  parameter logic [PFX_W-1:0] PFX_P = 7'b1111100,
  localparam int OFF_W = $clog2(CHAR_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CHAR_W-1:0] data_o,
  input logic              sync_o,
  input logic [CHAR_W-1:0] hit_vec,
  input logic              hit,
  input logic [OFF_W-1:0]  hit_off,
  input logic [OFF_W-1:0]  off_q
);
  logic [CHAR_W-1:0] below;
  always_comb below = (CHAR_W'(1) << hit_off) - CHAR_W'(1);

  AST_SYNC_IS_COMMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (data_o[PFX_W-1:0] == PFX_P || data_o[PFX_W-1:0] == ~PFX_P)); // R6

  AST_SYNC_FROM_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> $past(hit, 2)); // R6

  AST_OFF_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (off_q == $past(hit_off))); // R4

  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(off_q)); // R9

  AST_LOWEST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> ((hit_vec & below) == '0)); // R5
endmodule

bind cwa_aligner cwa_aligner_chk #(
  .CHAR_W (CHAR_W),
  .PFX_W  (PFX_W),
  .PFX_P  (PFX_P)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .data_o  (data_o),
  .sync_o  (sync_o),
  .hit_vec (hit_vec),
  .hit     (hit),
  .hit_off (hit_off),
  .off_q   (off_q)
);

// File: tb/cwa_aligner_tb.sv
`timescale 1ns/1ps
module cwa_aligner_tb;
  localparam int MAXB = 4096;
  localparam int MAXW = MAXB/10;
  localparam logic [9:0] K_NEG = 10'h17C;
  localparam logic [9:0] K_POS = 10'h283;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [9:0] din;
  logic [9:0] dout;
  logic       sync;

  cwa_aligner u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .data_i (din),
    .data_o (dout),
    .sync_o (sync)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic       stream [MAXB];
  int         len = 0;
  logic       ex_chk [MAXW];
  logic [9:0] ex_d   [MAXW];
  logic       ex_s   [MAXW];
  string      ex_tag [MAXW];
  int         didx = 0;
  logic [9:0] dpool [4] = '{10'h155, 10'h2AA, 10'h199, 10'h266};

  typedef struct {
    int         due;
    logic       chk;
    logic [9:0] d;
    logic       s;
    string      tag;
  } item_t;
  item_t q[$];
  item_t it;

  task automatic check(bit ok, string tag, logic [9:0] act, logic [9:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic put_bits(logic [9:0] v, int n);
    for (int i = 0; i < n; i++) begin
      stream[len] = v[i];
      len++;
    end
  endtask

  task automatic pad_to(int k, int extra);
    int n;
    n = ((k - len % 10) % 10 + 10) % 10 + extra;
    for (int i = 0; i < n; i++) begin
      stream[len] = logic'(i % 2);
      len++;
    end
  endtask

  task automatic put_char(logic [9:0] v, bit chk, bit s, string tag);
    int j;
    j = len / 10;
    if (chk) begin
      ex_chk[j] = 1'b1;
      ex_d[j]   = v;
      ex_s[j]   = s;
      ex_tag[j] = tag;
    end
    put_bits(v, 10);
  endtask

  function automatic logic [9:0] next_data();
    logic [9:0] v;
    v = dpool[didx % 4];
    didx++;
    return v;
  endfunction

  task automatic put_data(int n, bit chk, string tag);
    for (int i = 0; i < n; i++) put_char(next_data(), chk, 1'b0, tag);
  endtask

  task automatic build();
    for (int j = 0; j < MAXW; j++) begin
      ex_chk[j] = 1'b0;
      ex_d[j]   = '0;
      ex_s[j]   = 1'b0;
      ex_tag[j] = "";
    end
    // R1: phase 0 straight after reset, no comma
    put_data(6, 1'b1, "R1");
    // R4: realign to offset 3
    pad_to(3, 10); put_data(3, 1'b0, "");
    put_char(K_NEG, 1'b1, 1'b1, "R4"); put_data(5, 1'b1, "R4");
    // R8: comma already at offset 3
    pad_to(3, 10); put_data(3, 1'b1, "R8");
    put_char(K_POS, 1'b1, 1'b1, "R8"); put_data(3, 1'b1, "R8");
    // R3: positive disparity at offset 7, R2 cut and latency
    pad_to(7, 10); put_data(2, 1'b0, "");
    put_char(K_POS, 1'b1, 1'b1, "R3"); put_data(3, 1'b1, "R2");
    // R3: highest offset 9
    pad_to(9, 10); put_data(2, 1'b0, "");
    put_char(K_NEG, 1'b1, 1'b1, "R3"); put_data(3, 1'b1, "R3");
    // R5: offsets 0 and 5 match together
    pad_to(0, 10); put_data(2, 1'b0, "");
    put_char(10'h07C, 1'b1, 1'b1, "R5"); put_char(10'h154, 1'b1, 1'b0, "R5");
    put_data(3, 1'b1, "R5");
    // R6 / R7: back-to-back commas at offset 5
    pad_to(5, 10); put_data(2, 1'b0, "");
    put_char(K_NEG, 1'b1, 1'b1, "R6"); put_char(K_POS, 1'b1, 1'b1, "R7");
    put_data(3, 1'b1, "R7");
    // R9: long comma-free run at offset 1
    pad_to(1, 10); put_data(1, 1'b0, "");
    put_char(K_POS, 1'b1, 1'b1, "R6"); put_data(12, 1'b1, "R9");
    pad_to(0, 30);
  endtask

  always @(posedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      if (it.due == cyc && it.chk) begin
        check(dout == it.d, {it.tag, " data"}, dout, it.d);
        check(sync == it.s, {it.tag, " sync"}, {9'd0, sync}, {9'd0, it.s});
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R2 watchdog expired actual=%0d expected=<200000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [9:0] w;
    int nw;
    rst_n = 1'b0;
    din   = '0;
    build();
    nw = len / 10;
    repeat (3) @(negedge clk);
    check(dout == '0, "R1 data in reset", dout, '0);
    check(sync == 1'b0, "R1 sync in reset", {9'd0, sync}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout == '0, "R1 data after reset", dout, '0);
    check(sync == 1'b0, "R1 sync after reset", {9'd0, sync}, '0);
    for (int j = 0; j < nw; j++) begin
      @(negedge clk);
      for (int b = 0; b < 10; b++) w[b] = stream[j*10 + b];
      din = w;
      q.push_back('{cyc + 4, ex_chk[j], ex_d[j], ex_s[j], ex_tag[j]});
    end
    @(negedge clk);
    din = '0;
    repeat (8) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule